// File: doc/BRIEF.md
# Page-Table Walk Memory Request Scheduler

This block sits between a page-table walker and a memory port that may refuse a request or answer it with a negative acknowledgement (NACK). The walker hands it one pending table read at a time. Alongside that read it may hand over write-backs that set the accessed bit. The scheduler holds the read in a single slot and the write-backs in a small last-in-first-out stack. It issues at most one request per cycle, counts the transactions that are outstanding, and forwards each valid read response to the walker in the same cycle. The walker can then push its next read and write-back in that cycle.

When the port refuses a request, the scheduler stalls until the port signals retry. When a response comes back NACKed, the request is put back into the read slot or onto the write stack according to its type, and it competes for the port again at once. The walker learns that the walk has fully drained from a one-cycle pulse. The pulse is raised only when nothing is pending and nothing is outstanding. Only then may the translation result or fault be released.

The controller has four states, driven by two processes:
- `ST_IDLE`: nothing pending and nothing outstanding.
- `ST_ISSUE`: a request is presented on the port.
- `ST_STALL`: a refused request is waiting for retry.
- `ST_DRAIN`: nothing pending, but responses are still outstanding.

Its transitions are:
- A refusal moves the controller to `ST_STALL` from `ST_ISSUE`.
- `ST_STALL` is left only on retry, and only for `ST_ISSUE`.
- Otherwise the next state follows the next-cycle contents: pending work gives `ST_ISSUE`, outstanding responses alone give `ST_DRAIN`, and neither gives `ST_IDLE`.
- Entering `ST_IDLE` from any other state raises the drained pulse.

Top module: `ptw_req_sched`

## Requirements
- R1: While reset is held and right after it, no port request, no walker response, no drained pulse and no overflow flag is asserted.
- R2: When a read is pending, it is presented on the port before any queued write-back (`mem_req_write` = 0 for reads, 1 for writes).
- R3: A request presented with `mem_req_ready` low is refused. From the next cycle, nothing is presented until a cycle with `mem_retry` high. The same request is presented in the cycle after that retry.
- R4: Queued write-backs are issued newest first, one per cycle, for as long as the port accepts them. Each carries the address and data it was pushed with.
- R5: `walk_done` pulses for exactly one cycle. The pulse comes in the cycle after the cycle in which the last outstanding response arrived, with no read pending and an empty write stack. It never pulses while anything is pending or outstanding.
- R6: A read response that is not NACKed is forwarded combinationally on `wk_rsp_valid`/`wk_rsp_data`, but only if a read is outstanding. Write responses, NACKed responses and stray read responses are not forwarded, and a stray read response leaves the outstanding count unchanged.
- R7: A NACKed read returns to the read slot with its address and is presented again in the next cycle. If that re-send is refused, R3 applies.
- R8: A NACKed write returns to the top of the write stack with its address and data. It is issued after any pending read.
- R9: A write-back push into a full stack with no pop in the same cycle is dropped, and it raises `push_err` for one cycle in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wk_rd_push | input | 1 | Walker loads the pending read slot |
| wk_rd_addr | input | AW | Physical address of the table read |
| wk_wr_push | input | 1 | Walker pushes an accessed-bit write-back |
| wk_wr_addr | input | AW | Write-back address |
| wk_wr_data | input | DW | Write-back entry value |
| wk_rsp_valid | output | 1 | Read response forwarded to the walker |
| wk_rsp_data | output | DW | Forwarded read data |
| walk_done | output | 1 | One-cycle pulse: walk fully drained |
| push_err | output | 1 | Write-back push hit a full stack |
| mem_req_valid | output | 1 | Request presented on the port |
| mem_req_ready | input | 1 | Port accepts the presented request |
| mem_req_write | output | 1 | 1 = write-back, 0 = table read |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Write data (zero for reads) |
| mem_retry | input | 1 | Port may be tried again after a refusal |
| mem_rsp_valid | input | 1 | Response from the port |
| mem_rsp_write | input | 1 | 1 = write response, 0 = read response |
| mem_rsp_nack | input | 1 | Response is a negative acknowledgement |
| mem_rsp_addr | input | AW | Address of the answered request |
| mem_rsp_data | input | DW | Read data, or write data echoed on NACK |

## Verification
The hardest situation to reach is a NACK arriving while the port refuses the re-sent read in the very same cycle. This cycle also holds a second NACK for a write-back. It must end with one item in the read slot, one on the stack, a zero outstanding count and a stall. The stimulus gets there by issuing a read and a write back to back, answering both with NACKs in consecutive cycles, and holding `mem_req_ready` low during the second one. Stack overflow is reached by holding the port in a stall while more write-backs are pushed than the stack holds. The drain order after the retry then shows which entry was dropped.

// File: rtl/ptw_sched_pkg.sv
package ptw_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_STALL = 2'd2,
        ST_DRAIN = 2'd3
    } sched_st_e;

endpackage

// File: rtl/ptw_wb_lifo.sv
module ptw_wb_lifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 40,
    parameter int DW    = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [AW-1:0]                 push_addr,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [AW-1:0]                 top_addr,
    output logic [DW-1:0]                 top_data,
    output logic [$clog2(DEPTH+1)-1:0]    depth_q,
    output logic [$clog2(DEPTH+1)-1:0]    depth_d,
    output logic                          over_err
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [AW-1:0] addr_r [DEPTH];
    logic [DW-1:0] data_r [DEPTH];
    logic          full;
    logic [IW-1:0] top_idx;

    assign full    = (depth_q == FULL);
    assign top_idx = (depth_q == '0) ? '0 : IW'(depth_q - CW'(1));
    assign top_addr = addr_r[top_idx];
    assign top_data = data_r[top_idx];

    // Per-slot write enable: replace the top on push+pop, append otherwise.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic wen;
        assign wen = push && ((pop && depth_q != '0 && top_idx == IW'(i)) ||
                              (!pop && !full && depth_q == CW'(i)));
        always_ff @(posedge clk) begin
            if (wen) begin
                addr_r[i] <= push_addr;
                data_r[i] <= push_data;
            end
        end
    end

    always_comb begin
        unique case ({push, pop})
            2'b10:   depth_d = full ? depth_q : depth_q + CW'(1);
            2'b01:   depth_d = depth_q - CW'(1);
            default: depth_d = depth_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth_q  <= '0;
            over_err <= 1'b0;
        end else begin
            depth_q  <= depth_d;
            over_err <= push && !pop && full;
        end
    end
endmodule

// File: rtl/ptw_flight_ctr.sv
module ptw_flight_ctr #(
    parameter int MAX_FLIGHT = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              inc,
    input  logic                              dec,
    output logic [$clog2(MAX_FLIGHT+1)-1:0]   cnt_q,
    output logic [$clog2(MAX_FLIGHT+1)-1:0]   cnt_d
);
    localparam int FW = $clog2(MAX_FLIGHT + 1);

    logic dec_ok;
    assign dec_ok = dec && (cnt_q != '0);

    always_comb begin
        unique case ({inc, dec_ok})
            2'b10:   cnt_d = cnt_q + FW'(1);
            2'b01:   cnt_d = cnt_q - FW'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ptw_req_sched.sv
module ptw_req_sched
    import ptw_sched_pkg::*;
#(
    parameter int AW         = 40,
    parameter int DW         = 64,
    parameter int WB_DEPTH   = 4,
    parameter int MAX_FLIGHT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wk_rd_push,
    input  logic [AW-1:0] wk_rd_addr,
    input  logic          wk_wr_push,
    input  logic [AW-1:0] wk_wr_addr,
    input  logic [DW-1:0] wk_wr_data,
    output logic          wk_rsp_valid,
    output logic [DW-1:0] wk_rsp_data,
    output logic          walk_done,
    output logic          push_err,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic          mem_req_write,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_data,
    input  logic          mem_retry,
    input  logic          mem_rsp_valid,
    input  logic          mem_rsp_write,
    input  logic          mem_rsp_nack,
    input  logic [AW-1:0] mem_rsp_addr,
    input  logic [DW-1:0] mem_rsp_data
);
    localparam int QC_W = $clog2(WB_DEPTH + 1);
    localparam int FL_W = $clog2(MAX_FLIGHT + 1);

    sched_st_e     state_q, state_d;
    logic          done_q;
    logic          rd_pend_q, rd_pend_d;
    logic [AW-1:0] rd_addr_q, rd_addr_d;
    logic          rd_infl_q, rd_infl_d;

    logic          accept, refuse, rd_acc, wr_acc;
    logic          rsp_rd_ok, rsp_wr_ok, rsp_nack_rd, rsp_nack_wr, rsp_take;
    logic          q_push;
    logic [AW-1:0] q_push_addr, q_top_addr;
    logic [DW-1:0] q_push_data, q_top_data;
    logic [QC_W-1:0] q_depth_q, q_depth_d;
    logic [FL_W-1:0] fl_cnt_q, fl_cnt_d;
    logic          q_err;
    logic          work_d;

    // Port handshake decode
    assign accept = mem_req_valid && mem_req_ready;
    assign refuse = mem_req_valid && !mem_req_ready;
    assign rd_acc = accept && !mem_req_write;
    assign wr_acc = accept && mem_req_write;

    // Response classification
    assign rsp_nack_rd = mem_rsp_valid && mem_rsp_nack && !mem_rsp_write;
    assign rsp_nack_wr = mem_rsp_valid && mem_rsp_nack && mem_rsp_write;
    assign rsp_rd_ok   = mem_rsp_valid && !mem_rsp_nack && !mem_rsp_write && rd_infl_q;
    assign rsp_wr_ok   = mem_rsp_valid && !mem_rsp_nack && mem_rsp_write;
    assign rsp_take    = rsp_rd_ok || rsp_wr_ok || rsp_nack_rd || rsp_nack_wr;

    // Pending read slot: walker load or NACK return sets it, acceptance clears it
    assign rd_pend_d = wk_rd_push || rsp_nack_rd || (rd_pend_q && !rd_acc);
    assign rd_addr_d = wk_rd_push  ? wk_rd_addr  :
                       rsp_nack_rd ? mem_rsp_addr : rd_addr_q;
    assign rd_infl_d = rd_acc || (rd_infl_q && !(rsp_rd_ok || rsp_nack_rd));

    // Write-back stack sources: walker has precedence over a NACK return
    assign q_push      = wk_wr_push || rsp_nack_wr;
    assign q_push_addr = wk_wr_push ? wk_wr_addr : mem_rsp_addr;
    assign q_push_data = wk_wr_push ? wk_wr_data : mem_rsp_data;

    ptw_wb_lifo #(
        .DEPTH (WB_DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_addr (q_push_addr),
        .push_data (q_push_data),
        .pop       (wr_acc),
        .top_addr  (q_top_addr),
        .top_data  (q_top_data),
        .depth_q   (q_depth_q),
        .depth_d   (q_depth_d),
        .over_err  (q_err)
    );

    ptw_flight_ctr #(
        .MAX_FLIGHT (MAX_FLIGHT)
    ) u_flight (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (accept),
        .dec   (rsp_take),
        .cnt_q (fl_cnt_q),
        .cnt_d (fl_cnt_d)
    );

    assign work_d = rd_pend_d || (q_depth_d != '0);

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ISSUE: begin
                if (refuse)                   state_d = ST_STALL;
                else if (work_d)              state_d = ST_ISSUE;
                else if (fl_cnt_d != '0)      state_d = ST_DRAIN;
                else                          state_d = ST_IDLE;
            end
            ST_STALL: begin
                if (!mem_retry && work_d)     state_d = ST_STALL;
                else if (work_d)              state_d = ST_ISSUE;
                else if (fl_cnt_d != '0)      state_d = ST_DRAIN;
                else                          state_d = ST_IDLE;
            end
            ST_IDLE, ST_DRAIN: begin
                if (work_d)                   state_d = ST_ISSUE;
                else if (fl_cnt_d != '0)      state_d = ST_DRAIN;
                else                          state_d = ST_IDLE;
            end
            default:                          state_d = ST_IDLE;
        endcase
    end

    // State and slot registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b0;
            rd_pend_q <= 1'b0;
            rd_addr_q <= '0;
            rd_infl_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            done_q    <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
            rd_pend_q <= rd_pend_d;
            rd_addr_q <= rd_addr_d;
            rd_infl_q <= rd_infl_d;
        end
    end

    // Outputs
    always_comb begin
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_write = mem_req_valid && !rd_pend_q;
        mem_req_addr  = rd_pend_q ? rd_addr_q : q_top_addr;
        mem_req_data  = rd_pend_q ? '0 : q_top_data;
        wk_rsp_valid  = rsp_rd_ok;
        wk_rsp_data   = mem_rsp_data;
        walk_done     = done_q;
        push_err      = q_err;
    end
endmodule

// File: rtl/ptw_req_sched_chk.sv
module ptw_req_sched_chk #(
    parameter int WB_DEPTH   = 4,
    parameter int MAX_FLIGHT = 8
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               mem_req_valid,
    input logic                               mem_req_ready,
    input logic                               mem_req_write,
    input logic                               mem_rsp_valid,
    input logic                               mem_rsp_write,
    input logic                               mem_rsp_nack,
    input logic                               wk_rsp_valid,
    input logic                               walk_done,
    input logic                               push_err,
    input logic                               rd_pend,
    input logic [$clog2(MAX_FLIGHT+1)-1:0]    fl_cnt,
    input logic [$clog2(WB_DEPTH+1)-1:0]      q_depth
);
    localparam int QC_W = $clog2(WB_DEPTH + 1);
    localparam int FL_W = $clog2(MAX_FLIGHT + 1);
    localparam logic [QC_W-1:0] Q_FULL   = QC_W'(WB_DEPTH);
    localparam logic [FL_W-1:0] FL_LIMIT = FL_W'(MAX_FLIGHT);

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> !rd_pend);                      // R2

    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> !mem_req_valid);               // R3

    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> (fl_cnt == '0 && !rd_pend && q_depth == '0 && !mem_req_valid)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);                                           // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cnt <= FL_LIMIT);                                                 // R5

    AST_RSP_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wk_rsp_valid |-> (mem_rsp_valid && !mem_rsp_write && !mem_rsp_nack)); // R6

    AST_ERR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_err |-> ($past(q_depth) == Q_FULL));                            // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!walk_done && !push_err));                               // R1
endmodule

bind ptw_req_sched ptw_req_sched_chk #(
    .WB_DEPTH   (WB_DEPTH),
    .MAX_FLIGHT (MAX_FLIGHT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_write (mem_rsp_write),
    .mem_rsp_nack  (mem_rsp_nack),
    .wk_rsp_valid  (wk_rsp_valid),
    .walk_done     (walk_done),
    .push_err      (push_err),
    .rd_pend       (rd_pend_q),
    .fl_cnt        (fl_cnt_q),
    .q_depth       (q_depth_q)
);

// File: tb/tb_ptw_req_sched.sv
`timescale 1ns/1ps
module tb_ptw_req_sched;
    localparam int AW = 40;
    localparam int DW = 64;
    localparam int NV = 38;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wk_rd_push = 0, wk_wr_push = 0;
    logic [AW-1:0] wk_rd_addr = '0, wk_wr_addr = '0;
    logic [DW-1:0] wk_wr_data = '0;
    logic          wk_rsp_valid, walk_done, push_err;
    logic [DW-1:0] wk_rsp_data;
    logic          mem_req_valid, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_data;
    logic          mem_req_ready = 0, mem_retry = 0;
    logic          mem_rsp_valid = 0, mem_rsp_write = 0, mem_rsp_nack = 0;
    logic [AW-1:0] mem_rsp_addr = '0;
    logic [DW-1:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ptw_req_sched #(.AW(AW), .DW(DW), .WB_DEPTH(4), .MAX_FLIGHT(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .wk_rd_push(wk_rd_push), .wk_rd_addr(wk_rd_addr),
        .wk_wr_push(wk_wr_push), .wk_wr_addr(wk_wr_addr), .wk_wr_data(wk_wr_data),
        .wk_rsp_valid(wk_rsp_valid), .wk_rsp_data(wk_rsp_data),
        .walk_done(walk_done), .push_err(push_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .mem_retry(mem_retry),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_write(mem_rsp_write),
        .mem_rsp_nack(mem_rsp_nack), .mem_rsp_addr(mem_rsp_addr),
        .mem_rsp_data(mem_rsp_data)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       rd, wr, rdy, rty, rv, rw, rn;
        logic [7:0] a, b;
        logic       ev, ew;
        logic [7:0] ea;
        logic       ed, er;
    } vec_t;

    // req | rd wr rdy rty rv rw rn | a b | exp valid write addr | exp done rsp
    localparam vec_t TBL [NV] = '{
        '{4'd6, 1,0,0,0,0,0,0,  10, 0, 0,0, 0, 0,0},  // walk A: load read
        '{4'd2, 0,0,1,0,0,0,0,   0, 0, 1,0,10, 0,0},  // R2 read issued
        '{4'd5, 0,0,0,0,0,0,0,   0, 0, 0,0, 0, 0,0},  // R5 outstanding, no pulse
        '{4'd6, 1,1,0,0,1,0,0,  20,11, 0,0, 0, 0,1},  // R6 forward + push next
        '{4'd2, 0,0,1,0,0,0,0,   0, 0, 1,0,20, 0,0},  // R2 read before write
        '{4'd4, 0,0,1,0,0,0,0,   0, 0, 1,1,11, 0,0},  // R4 write-back
        '{4'd6, 0,0,0,0,1,1,0,  11, 0, 0,0, 0, 0,0},  // R6 write rsp not forwarded
        '{4'd6, 0,0,0,0,1,0,0,  20, 0, 0,0, 0, 0,1},  // R6 last read rsp
        '{4'd5, 0,0,0,0,0,0,0,   0, 0, 0,0, 0, 1,0},  // R5 drained pulse
        '{4'd5, 0,0,0,0,0,0,0,   0, 0, 0,0, 0, 0,0},  // R5 pulse is one cycle
        '{4'd2, 1,1,0,0,0,0,0,  30,31, 0,0, 0, 0,0},  // walk B
        '{4'd3, 0,0,0,0,0,0,0,   0, 0, 1,0,30, 0,0},  // R3 refused
        '{4'd3, 0,0,1,0,0,0,0,   0, 0, 0,0, 0, 0,0},  // R3 stalled despite ready
        '{4'd3, 0,0,1,1,0,0,0,   0, 0, 0,0, 0, 0,0},  // R3 retry cycle
        '{4'd3, 0,0,1,0,0,0,0,   0, 0, 1,0,30, 0,0},  // R3 same request resent
        '{4'd3, 0,0,0,0,0,0,0,   0, 0, 1,1,31, 0,0},  // R3 write refused
        '{4'd6, 1,1,0,0,1,0,0,  40,41, 0,0, 0, 0,1},  // R6 forwarded during stall
        '{4'd3, 0,0,0,1,0,0,0,   0, 0, 0,0, 0, 0,0},  // R3 retry
        '{4'd2, 0,0,1,0,0,0,0,   0, 0, 1,0,40, 0,0},  // R2
        '{4'd4, 0,0,1,0,0,0,0,   0, 0, 1,1,41, 0,0},  // R4 newest first
        '{4'd4, 0,0,1,0,0,0,0,   0, 0, 1,1,31, 0,0},  // R4 older entry
        '{4'd6, 0,0,0,0,1,1,0,  41, 0, 0,0, 0, 0,0},
        '{4'd6, 0,0,0,0,1,1,0,  31, 0, 0,0, 0, 0,0},
        '{4'd6, 0,0,0,0,1,0,0,  40, 0, 0,0, 0, 0,1},
        '{4'd5, 0,0,0,0,0,0,0,   0, 0, 0,0, 0, 1,0},  // R5
        '{4'd2, 1,1,0,0,0,0,0,  50,51, 0,0, 0, 0,0},  // walk C
        '{4'd2, 0,0,1,0,0,0,0,   0, 0, 1,0,50, 0,0},
        '{4'd4, 0,0,1,0,0,0,0,   0, 0, 1,1,51, 0,0},
        '{4'd7, 0,0,0,0,1,0,1,  50, 0, 0,0, 0, 0,0},  // R7 NACK read, not forwarded
        '{4'd7, 0,0,0,0,1,1,1,  51, 0, 1,0,50, 0,0},  // R7 resend refused + NACK write
        '{4'd3, 0,0,0,1,0,0,0,   0, 0, 0,0, 0, 0,0},  // R3 retry
        '{4'd8, 0,0,1,0,0,0,0,   0, 0, 1,0,50, 0,0},  // R8 read first
        '{4'd8, 0,0,1,0,0,0,0,   0, 0, 1,1,51, 0,0},  // R8 NACKed write reissued
        '{4'd6, 0,0,0,0,1,1,0,  51, 0, 0,0, 0, 0,0},
        '{4'd6, 0,0,0,0,1,0,0,  50, 0, 0,0, 0, 0,1},
        '{4'd5, 0,0,0,0,0,0,0,   0, 0, 0,0, 0, 1,0},  // R5
        '{4'd6, 0,0,0,0,1,0,0,  60, 0, 0,0, 0, 0,0},  // R6 stray read ignored
        '{4'd6, 0,0,0,0,0,0,0,   0, 0, 0,0, 0, 0,0}   // R6 no walk started by it
    };

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic wr, input logic rdy, input logic rty,
                         input logic rv, input logic rw, input logic rn,
                         input logic [7:0] a, input logic [7:0] b);
        wk_rd_push    = rd;
        wk_rd_addr    = AW'(a);
        wk_wr_push    = wr;
        wk_wr_addr    = AW'(b);
        wk_wr_data    = {8{b}};
        mem_req_ready = rdy;
        mem_retry     = rty;
        mem_rsp_valid = rv;
        mem_rsp_write = rw;
        mem_rsp_nack  = rn;
        mem_rsp_addr  = AW'(a);
        mem_rsp_data  = {8{a}};
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        drive(0,0,0,0,0,0,0,0,0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "walk_done", 64'(walk_done), 64'd0);
        chk("R1", "push_err", 64'(push_err), 64'd0);
        chk("R1", "rsp_valid", 64'(wk_rsp_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "req_valid after reset", 64'(mem_req_valid), 64'd0);
        chk("R1", "done after reset", 64'(walk_done), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            @(negedge clk);
            drive(TBL[i].rd, TBL[i].wr, TBL[i].rdy, TBL[i].rty,
                  TBL[i].rv, TBL[i].rw, TBL[i].rn, TBL[i].a, TBL[i].b);
            #1;
            tag = $sformatf("R%0d row %0d", TBL[i].req, i);
            chk(tag, "req_valid", 64'(mem_req_valid), 64'(TBL[i].ev));
            if (TBL[i].ev) begin
                chk(tag, "req_write", 64'(mem_req_write), 64'(TBL[i].ew));
                chk(tag, "req_addr", 64'(mem_req_addr), 64'(TBL[i].ea));
                if (TBL[i].ew)
                    chk(tag, "req_data", mem_req_data, {8{TBL[i].ea}});
            end
            chk(tag, "walk_done", 64'(walk_done), 64'(TBL[i].ed));
            chk(tag, "rsp_valid", 64'(wk_rsp_valid), 64'(TBL[i].er));
            if (TBL[i].er)
                chk(tag, "rsp_data", wk_rsp_data, {8{TBL[i].a}});
        end

        // R9 overflow: stall the port and push one more than the stack holds
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            drive(0,1,0,0,0,0,0,0,8'(k));
            #1;
            chk("R9", "no error before overflow", 64'(push_err), 64'd0);
        end
        @(negedge clk);
        drive(0,0,0,0,0,0,0,0,0);
        #1;
        chk("R9", "error after full push", 64'(push_err), 64'd1);
        @(negedge clk);
        #1;
        chk("R9", "error is a pulse", 64'(push_err), 64'd0);
        chk("R3", "quiet while stalled", 64'(mem_req_valid), 64'd0);
        @(negedge clk);
        drive(0,0,0,1,0,0,0,0,0);
        #1;
        for (int k = 4; k >= 1; k--) begin
            @(negedge clk);
            drive(0,0,1,0,0,0,0,0,0);
            #1;
            chk("R9", "drain valid", 64'(mem_req_valid), 64'd1);
            chk("R4", "drain order", 64'(mem_req_addr), 64'(k));
            chk("R4", "drain data", mem_req_data, {8{8'(k)}});
        end
        @(negedge clk);
        drive(0,0,0,0,0,0,0,0,0);
        #1;
        chk("R9", "dropped entry not issued", 64'(mem_req_valid), 64'd0);
        for (int k = 4; k >= 1; k--) begin
            @(negedge clk);
            drive(0,0,0,0,1,1,0,8'(k),0);
            #1;
            chk("R5", "no pulse while outstanding", 64'(walk_done), 64'd0);
        end
        @(negedge clk);
        drive(0,0,0,0,0,0,0,0,0);
        #1;
        chk("R5", "pulse after last write rsp", 64'(walk_done), 64'd1);

        summary();
        $finish;
    end
endmodule